// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Command Decoder

This block sits behind a serial receiver and turns each complete 16-bit command word into register updates for a two-channel 12-bit converter. Each channel keeps a staging (input) register and a live (output) register, so new codes can be staged on one or both channels and then made live together. The block also holds a shutdown flag for each channel, a general-purpose user output pin and the bit that selects the clock edge used by the serial data output.

A word is presented on `cmd_word` together with a one-cycle `cmd_valid` strobe. The three top bits of the word form an operation field. When that field is zero, the top four data bits select a control sub-operation instead. A lockout input blocks every shutdown request while low, and pulling it low wakes any channel already in shutdown. An active-low clear and the power-on reset both return the whole state to zero.

Top module: `dual_dac_cmd_decoder`

## Requirements
- R1: The word layout is: bits 15..13 hold the operation field, bits 12..1 hold the 12 data bits (bit 12 is the data MSB), and bit 0 is unused. Operation 001 writes the data into staging register A, and operation 101 writes it into staging register B. Neither changes any live register or shutdown flag.
- R2: Operation 011 writes the data into staging A and live A and copies staging B into live B. Operation 111 writes the data into staging B and live B and copies staging A into live A.
- R3: Operation 010 writes the data into both live registers. Both staging registers keep their contents.
- R4: Operation 100 copies each staging register into its own live register. With operation 000, sub-code 001 (data bits 11..9) copies staging A into live A only, and sub-code 101 copies staging B into live B only.
- R5: With the lockout input high, operation 110 sets both shutdown flags. Sub-code 110 sets the A flag only, and sub-code 111 sets the B flag only. Register contents are kept.
- R6: Every command that writes a channel's live register clears that channel's shutdown flag. A load into a staging register alone leaves the flag as it is.
- R7: While the lockout input is low, shutdown commands change nothing and are not held for later. Driving the lockout input low clears both flags at once, without waiting for a clock, and the live registers keep their values.
- R8: Sub-code 010 drives the user output low, and sub-code 011 drives it high.
- R9: Sub-code 100 loads the edge-mode bit from data bit 8: 1001 gives mode 1 (output changes on the rising edge), and 1000 gives mode 0 (output changes on the falling edge).
- R10: Sub-code 000 (no-op) changes no output, whatever the lower data bits hold.
- R11: The clear input and the reset input act asynchronously. Either one sets all registers, flags, the user output and the mode bit to zero. A clear wins over a command strobed in the same cycle.
- R12: A strobed command shows at the outputs after the next rising clock edge. A word presented without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clear_n | input | 1 | Asynchronous active-low clear of all state |
| lockout_n | input | 1 | Low blocks shutdown; a low level also wakes both channels |
| cmd_word | input | 16 | Received command word |
| cmd_valid | input | 1 | One-cycle strobe marking `cmd_word` as valid |
| out_a | output | 12 | Live register of channel A |
| out_b | output | 12 | Live register of channel B |
| shdn_a | output | 1 | Channel A is in shutdown |
| shdn_b | output | 1 | Channel B is in shutdown |
| user_out | output | 1 | User output pin |
| edge_mode | output | 1 | Serial output edge: 1 = rising, 0 = falling |

## Verification
The bench targets the cross-channel copies of the combined load-and-update operations. A design that swapped the data and staging sources there would put the new code on the wrong live register. The direct write is followed by an update to show that the staging registers survived it; a design that also wrote staging would restore the direct value. The lockout is checked in three ways: shutdown requests made while it is low, its release afterwards (a design that queued the request would then shut down late), and its falling edge with no clock (a design that woke only on a clock edge would leave the flags set). A clear that arrives in the same cycle as a command is also checked; a design that let the command win would show non-zero live values.

// File: rtl/dual_dac_cmd_decoder.sv
module dual_dac_cmd_decoder #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_n,
  input  logic          lockout_n,
  input  logic [DW+3:0] cmd_word,
  input  logic          cmd_valid,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic          shdn_a,
  output logic          shdn_b,
  output logic          user_out,
  output logic          edge_mode
);
  localparam int WW = DW + 4;

  logic [2:0]    op;
  logic [DW-1:0] data;
  logic [2:0]    sub;
  logic          ctl;
  logic [DW-1:0] in_a, in_b;

  assign op   = cmd_word[WW-1:WW-3];
  assign data = cmd_word[DW:1];
  assign sub  = data[DW-1:DW-3];
  assign ctl  = cmd_valid && (op == 3'b000);

  wire data_rst_n = rst_n & clear_n;
  wire flag_rst_n = data_rst_n & lockout_n;

  wire ld_in_a  = cmd_valid && (op == 3'b001 || op == 3'b011);
  wire ld_in_b  = cmd_valid && (op == 3'b101 || op == 3'b111);
  wire wr_out_a = (cmd_valid && (op == 3'b011 || op == 3'b010 ||
                                 op == 3'b100 || op == 3'b111)) ||
                  (ctl && sub == 3'b001);
  wire wr_out_b = (cmd_valid && (op == 3'b011 || op == 3'b010 ||
                                 op == 3'b100 || op == 3'b111)) ||
                  (ctl && sub == 3'b101);
  wire [DW-1:0] nxt_a = (op == 3'b010 || op == 3'b011) ? data : in_a;
  wire [DW-1:0] nxt_b = (op == 3'b010 || op == 3'b111) ? data : in_b;

  wire shut_a = lockout_n && ((cmd_valid && op == 3'b110) || (ctl && sub == 3'b110));
  wire shut_b = lockout_n && ((cmd_valid && op == 3'b110) || (ctl && sub == 3'b111));

  always_ff @(posedge clk or negedge data_rst_n) begin
    if (!data_rst_n) begin
      in_a  <= '0;
      in_b  <= '0;
      out_a <= '0;
      out_b <= '0;
    end else begin
      if (ld_in_a)  in_a  <= data;
      if (ld_in_b)  in_b  <= data;
      if (wr_out_a) out_a <= nxt_a;
      if (wr_out_b) out_b <= nxt_b;
    end
  end

  always_ff @(posedge clk or negedge data_rst_n) begin
    if (!data_rst_n) begin
      user_out  <= 1'b0;
      edge_mode <= 1'b0;
    end else if (ctl) begin
      if (sub == 3'b010) user_out <= 1'b0;
      if (sub == 3'b011) user_out <= 1'b1;
      if (sub == 3'b100) edge_mode <= data[DW-4];
    end
  end

  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n) begin
      shdn_a <= 1'b0;
      shdn_b <= 1'b0;
    end else begin
      if (wr_out_a)    shdn_a <= 1'b0;
      else if (shut_a) shdn_a <= 1'b1;
      if (wr_out_b)    shdn_b <= 1'b0;
      else if (shut_b) shdn_b <= 1'b1;
    end
  end
endmodule

module dual_dac_cmd_decoder_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_n,
  input logic          lockout_n,
  input logic [DW+3:0] cmd_word,
  input logic          cmd_valid,
  input logic [DW-1:0] out_a,
  input logic [DW-1:0] out_b,
  input logic          shdn_a,
  input logic          shdn_b,
  input logic          user_out,
  input logic          edge_mode
);
  assert_stage_only_R1: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
    (cmd_valid && (cmd_word[DW+3:DW+1] == 3'b001 || cmd_word[DW+3:DW+1] == 3'b101))
      |=> ($stable(out_a) && $stable(out_b) && $stable(shdn_a) && $stable(shdn_b)));

  assert_direct_write_R3: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
    (cmd_valid && cmd_word[DW+3:DW+1] == 3'b010)
      |=> (out_a == $past(cmd_word[DW:1]) && out_b == $past(cmd_word[DW:1])));

  assert_lockout_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lockout_n) |-> (!shdn_a && !shdn_b));

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n) |-> (out_a == '0 && out_b == '0 && !user_out && !edge_mode));

  assert_user_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
    (!$past(cmd_valid)) |-> ($stable(user_out) && $stable(edge_mode)));
endmodule

bind dual_dac_cmd_decoder dual_dac_cmd_decoder_chk #(.DW(DW)) u_chk (.*);

// File: tb/dual_dac_cmd_decoder_tb.sv
module dual_dac_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_n = 1'b1;
  logic        lockout_n = 1'b1;
  logic [15:0] cmd_word = '0;
  logic        cmd_valid = 1'b0;
  logic [11:0] out_a, out_b;
  logic        shdn_a, shdn_b, user_out, edge_mode;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dual_dac_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .lockout_n(lockout_n),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .out_a(out_a), .out_b(out_b), .shdn_a(shdn_a), .shdn_b(shdn_b),
    .user_out(user_out), .edge_mode(edge_mode)
  );

  function automatic logic [15:0] mk(input logic [2:0] op, input logic [11:0] d);
    return {op, d, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [11:0] d);
    @(negedge clk);
    cmd_word  = mk(op, d);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset out_a", out_a, 0);
    chk("R11 reset out_b", out_b, 0);
    chk("R11 reset flags", {shdn_a, shdn_b, user_out, edge_mode}, 0);
  endtask

  task automatic t_stage();
    send(3'b001, 12'h123);
    chk("R1 stage A leaves out_a", out_a, 0);
    send(3'b101, 12'h456);
    chk("R1 stage B leaves out_b", out_b, 0);
    send(3'b100, 12'h000);
    chk("R4 update both A", out_a, 12'h123);
    chk("R4 update both B", out_b, 12'h456);
  endtask

  task automatic t_load_update();
    send(3'b011, 12'h789);
    chk("R2 op011 out_a", out_a, 12'h789);
    chk("R2 op011 out_b", out_b, 12'h456);
    send(3'b111, 12'hABC);
    chk("R2 op111 out_b", out_b, 12'hABC);
    chk("R2 op111 out_a", out_a, 12'h789);
  endtask

  task automatic t_direct();
    send(3'b010, 12'h5A5);
    chk("R3 direct both", {out_a, out_b}, {12'h5A5, 12'h5A5});
    send(3'b100, 12'h000);
    chk("R3 staging kept", {out_a, out_b}, {12'h789, 12'hABC});
  endtask

  task automatic t_shutdown();
    send(3'b110, 12'h000);
    chk("R5 shut both flags", {shdn_a, shdn_b}, 2'b11);
    chk("R5 shut keeps data", {out_a, out_b}, {12'h789, 12'hABC});
    send(3'b001, 12'h111);
    chk("R6 stage does not wake", {shdn_a, out_a}, {1'b1, 12'h789});
    send(3'b100, 12'h000);
    chk("R6 update wakes", {shdn_a, shdn_b}, 2'b00);
    chk("R6 update value", out_a, 12'h111);
  endtask

  task automatic t_sub();
    send(3'b000, 12'hC00);
    chk("R5 shut A only", {shdn_a, shdn_b}, 2'b10);
    send(3'b000, 12'h200);
    chk("R6 sub update A wakes", {shdn_a, out_a}, {1'b0, 12'h111});
    send(3'b000, 12'hE00);
    chk("R5 shut B only", {shdn_a, shdn_b}, 2'b01);
    send(3'b101, 12'h222);
    send(3'b000, 12'hA00);
    chk("R4 sub update B", {shdn_b, out_b, out_a}, {1'b0, 12'h222, 12'h111});
  endtask

  task automatic t_user_mode();
    send(3'b000, 12'h600);
    chk("R8 user high", user_out, 1);
    send(3'b000, 12'h400);
    chk("R8 user low", user_out, 0);
    send(3'b000, 12'h900);
    chk("R9 mode 1", edge_mode, 1);
    send(3'b000, 12'h800);
    chk("R9 mode 0", edge_mode, 0);
    send(3'b000, 12'h900);
    send(3'b000, 12'h600);
  endtask

  task automatic t_nop();
    send(3'b000, 12'h0FF);
    chk("R10 nop data", {out_a, out_b}, {12'h111, 12'h222});
    chk("R10 nop flags", {shdn_a, shdn_b, user_out, edge_mode}, 4'b0011);
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    cmd_word = mk(3'b010, 12'hFFF);
    repeat (2) @(negedge clk);
    chk("R12 no strobe", {out_a, out_b}, {12'h111, 12'h222});
    cmd_word = '0;
  endtask

  task automatic t_lockout();
    lockout_n = 1'b0;
    send(3'b110, 12'h000);
    chk("R7 locked op110", {shdn_a, shdn_b}, 2'b00);
    send(3'b000, 12'hC00);
    chk("R7 locked sub shut", {shdn_a, shdn_b}, 2'b00);
    lockout_n = 1'b1;
    @(negedge clk);
    chk("R7 not queued", {shdn_a, shdn_b}, 2'b00);
    send(3'b110, 12'h000);
    chk("R7 unlocked shut", {shdn_a, shdn_b}, 2'b11);
    #2 lockout_n = 1'b0;
    #1;
    chk("R7 async wake", {shdn_a, shdn_b}, 2'b00);
    chk("R7 wake keeps data", {out_a, out_b}, {12'h111, 12'h222});
    @(negedge clk);
    lockout_n = 1'b1;
  endtask

  task automatic t_clear();
    send(3'b110, 12'h000);
    #2 clear_n = 1'b0;
    #1;
    chk("R11 async clear data", {out_a, out_b}, 0);
    chk("R11 async clear flags", {shdn_a, shdn_b, user_out, edge_mode}, 0);
    @(negedge clk);
    clear_n = 1'b1;
    send(3'b010, 12'h333);
    chk("R12 strobe applied", out_a, 12'h333);
    @(negedge clk);
    cmd_word  = mk(3'b010, 12'h444);
    cmd_valid = 1'b1;
    clear_n   = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    clear_n   = 1'b1;
    chk("R11 clear beats command", {out_a, out_b}, 0);
    send(3'b100, 12'h000);
    chk("R11 staging cleared", {out_a, out_b}, 0);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_load_update();
    t_direct();
    t_shutdown();
    t_sub();
    t_user_mode();
    t_nop();
    t_no_strobe();
    t_lockout();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule